// File: doc/BRIEF.md
# Quadrature Phase Error Corrector

Two quadrature channels taken from one interference order should be exactly 90 degrees apart. Assembly stress or adhesive creep can leave the cosine-like channel off by a fixed angle sigma. This block restores orthogonality in real time. It treats the sine-like channel as the reference. It rebuilds the cosine as cos(theta) = (cos(theta - sigma) - sin(theta) * sin(sigma)) / cos(sigma).

The sample path is a three-stage pipeline. The first stage multiplies the reference by sin(sigma). The second stage subtracts that product from the aligned measured cosine. The third stage scales the difference by a supplied reciprocal of cos(sigma) and saturates the result to 16 bits. Both constants are precomputed elsewhere and arrive as static inputs, so no trigonometry or divider is built. The reference sample travels with the corrected sample, which keeps the output pair aligned. A sample is accepted on each clock where the valid input is high. One instance handles one diffraction order, so a system with two orders uses two instances.

Top module: `qphase_corrector`

## Requirements
- R1: With in_ref = r, in_cos = c, sin_sigma = s and inv_cos = k, all signed, and s and k in Q2.14 (16384 = 1.0), out_cos equals floor(((c * 16384) - r * s) * k / 2^28), clamped to the signed 16-bit range.
- R2: A sample taken with in_valid high produces out_valid high exactly three clock cycles later. out_valid is low in every other cycle.
- R3: out_ref equals the in_ref of the same sample, unchanged, with the same three-cycle delay as out_cos.
- R4: With sin_sigma = 0 and inv_cos = 16384, out_cos equals the in_cos of the same sample.
- R5: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R6: In a cycle where out_valid is low, out_cos and out_ref keep their previous values.
- R7: While rst_n is low, out_valid, out_cos and out_ref are 0.
- R8: Samples presented on consecutive cycles each emerge on consecutive cycles, with no bubbles and no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_ref | input | 16 | Reference sine-like sample, signed |
| in_cos | input | 16 | Measured cosine-like sample carrying the phase error, signed |
| sin_sigma | input | 16 | sin(sigma) in signed Q2.14, held static while samples are in flight |
| inv_cos | input | 16 | 1/cos(sigma) in signed Q2.14, held static while samples are in flight |
| out_valid | output | 1 | Output sample qualifier |
| out_ref | output | 16 | Delayed reference sample |
| out_cos | output | 16 | Corrected cosine sample |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 16-bit coefficients with 14 fraction bits, and therefore a 33-bit difference and a 49-bit scaled product. At these widths a reciprocal near 2.0 together with full-scale inputs of opposite sign drives the scaled product past both 16-bit limits, so the two saturation branches can be reached with simple directed samples. The same widths allow the identity coefficients and a realistic 10-degree error to be checked exactly against floor arithmetic on 64-bit integers.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int QPC_DATA_W_DEF = 16;
  localparam int QPC_COEF_W_DEF = 16;
  localparam int QPC_FRAC_DEF   = 14;
  localparam int QPC_STAGES     = 3;
endpackage

// File: rtl/qpc_mul_stage.sv
module qpc_mul_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic signed [DATA_W-1:0] cos_i,
  input  logic signed [COEF_W-1:0] sin_i,
  output logic                     v_o,
  output logic signed [DATA_W-1:0] ref_o,
  output logic signed [DATA_W-1:0] cos_o,
  output logic signed [PROD_W-1:0] prod_o
);
  function automatic logic signed [PROD_W-1:0] leak_term(
    input logic signed [DATA_W-1:0] a, input logic signed [COEF_W-1:0] b);
    logic signed [PROD_W-1:0] ax, bx;
    ax = PROD_W'(a);
    bx = PROD_W'(b);
    return ax * bx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      ref_o  <= '0;
      cos_o  <= '0;
      prod_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        ref_o  <= ref_i;
        cos_o  <= cos_i;
        prod_o <= leak_term(ref_i, sin_i);
      end
    end
  end
endmodule

// File: rtl/qpc_sub_stage.sv
module qpc_sub_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int DIFF_W = PROD_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic signed [DATA_W-1:0] cos_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic                     v_o,
  output logic signed [DATA_W-1:0] ref_o,
  output logic signed [DIFF_W-1:0] diff_o
);
  function automatic logic signed [DIFF_W-1:0] cancel(
    input logic signed [DATA_W-1:0] c, input logic signed [PROD_W-1:0] p);
    logic signed [DIFF_W-1:0] cx, px;
    cx = DIFF_W'(c);
    px = DIFF_W'(p);
    return (cx <<< FRAC) - px;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      ref_o  <= '0;
      diff_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        ref_o  <= ref_i;
        diff_o <= cancel(cos_i, prod_i);
      end
    end
  end
endmodule

// File: rtl/qpc_scale_stage.sv
module qpc_scale_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14,
  localparam int DIFF_W = DATA_W + COEF_W + 1,
  localparam int SCL_W  = DIFF_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic signed [DATA_W-1:0] ref_i,
  input  logic signed [DIFF_W-1:0] diff_i,
  input  logic signed [COEF_W-1:0] inv_i,
  output logic                     v_o,
  output logic signed [DATA_W-1:0] ref_o,
  output logic signed [DATA_W-1:0] cos_o,
  output logic                     sat_o
);
  localparam logic signed [SCL_W-1:0] HI =
    {{(SCL_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SCL_W-1:0] LO =
    {{(SCL_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  function automatic logic signed [SCL_W-1:0] rescale(
    input logic signed [DIFF_W-1:0] d, input logic signed [COEF_W-1:0] k);
    logic signed [SCL_W-1:0] dx, kx;
    dx = SCL_W'(d);
    kx = SCL_W'(k);
    return (dx * kx) >>> (2 * FRAC);
  endfunction

  logic signed [SCL_W-1:0] wide;
  logic                    over_hi, under_lo;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    wide     = rescale(diff_i, inv_i);
    over_hi  = wide > HI;
    under_lo = wide < LO;
    if (over_hi)       clamped = HI[DATA_W-1:0];
    else if (under_lo) clamped = LO[DATA_W-1:0];
    else               clamped = wide[DATA_W-1:0];
  end

  assign sat_o = v_i && (over_hi || under_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      ref_o <= '0;
      cos_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        ref_o <= ref_i;
        cos_o <= clamped;
      end
    end
  end
endmodule

// File: rtl/qphase_corrector.sv
module qphase_corrector
  import qpc_pkg::*;
#(
  parameter int DATA_W = QPC_DATA_W_DEF,
  parameter int COEF_W = QPC_COEF_W_DEF,
  parameter int FRAC   = QPC_FRAC_DEF,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int DIFF_W = PROD_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_ref,
  input  logic signed [DATA_W-1:0] in_cos,
  input  logic signed [COEF_W-1:0] sin_sigma,
  input  logic signed [COEF_W-1:0] inv_cos,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_ref,
  output logic signed [DATA_W-1:0] out_cos
);
  logic                     m_v, s_v;
  logic signed [DATA_W-1:0] m_ref, m_cos, s_ref;
  logic signed [PROD_W-1:0] m_prod;
  logic signed [DIFF_W-1:0] s_diff;
  logic                     sat_event;

  qpc_mul_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .v_i(in_valid), .ref_i(in_ref), .cos_i(in_cos),
    .sin_i(sin_sigma), .v_o(m_v), .ref_o(m_ref), .cos_o(m_cos), .prod_o(m_prod));

  qpc_sub_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_sub (
    .clk(clk), .rst_n(rst_n), .v_i(m_v), .ref_i(m_ref), .cos_i(m_cos),
    .prod_i(m_prod), .v_o(s_v), .ref_o(s_ref), .diff_o(s_diff));

  qpc_scale_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_scl (
    .clk(clk), .rst_n(rst_n), .v_i(s_v), .ref_i(s_ref), .diff_i(s_diff),
    .inv_i(inv_cos), .v_o(out_valid), .ref_o(out_ref), .cos_o(out_cos),
    .sat_o(sat_event));
endmodule

// File: rtl/qphase_corrector_chk.sv
module qphase_corrector_chk #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_ref,
  input logic signed [DATA_W-1:0] in_cos,
  input logic signed [COEF_W-1:0] sin_sigma,
  input logic signed [COEF_W-1:0] inv_cos,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_ref,
  input logic signed [DATA_W-1:0] out_cos,
  input logic                     sat_event
);
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [COEF_W-1:0] ONE  = COEF_W'(1) <<< FRAC;

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r7: assert (!out_valid && out_cos == '0 && out_ref == '0)
        else $error("R7 outputs not cleared in reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_ref_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3)) |-> (out_ref == $past(in_ref, 3)));

  p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(in_valid, 3) && $past(sin_sigma, 3) == '0 &&
     $past(inv_cos, 1) == ONE) |-> (out_cos == $past(in_cos, 3)));

  p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> (out_cos == MAXV || out_cos == MINV));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !out_valid) |-> ($stable(out_cos) && $stable(out_ref)));
endmodule

bind qphase_corrector qphase_corrector_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ref(in_ref),
  .in_cos(in_cos), .sin_sigma(sin_sigma), .inv_cos(inv_cos),
  .out_valid(out_valid), .out_ref(out_ref), .out_cos(out_cos),
  .sat_event(sat_event)
);

// File: tb/qphase_corrector_test.sv
module qphase_corrector_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_ref, in_cos, sin_sigma, inv_cos;
  logic               out_valid;
  logic signed [15:0] out_ref, out_cos;

  qphase_corrector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ref(in_ref),
    .in_cos(in_cos), .sin_sigma(sin_sigma), .inv_cos(inv_cos),
    .out_valid(out_valid), .out_ref(out_ref), .out_cos(out_cos));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit     pv [1:3];
  longint pref [1:3];
  longint pexp [1:3];
  string  ptag [1:3];
  longint last_ref = 0, last_cos = 0;

  function automatic longint expect_cos(longint c, longint r, longint s, longint k);
    longint num, q;
    num = c * 16384 - r * s;
    q = (num * k) >>> 28;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, longint r, longint c, string tag);
    @(negedge clk);
    if (pv[3]) begin
      chk(out_valid == 1'b1, {tag, " R2 valid"}, longint'(out_valid), 1);
      chk(longint'(out_cos) == pexp[3], {ptag[3], " cos"}, longint'(out_cos), pexp[3]);
      chk(longint'(out_ref) == pref[3], "R3 ref", longint'(out_ref), pref[3]);
      last_cos = pexp[3];
      last_ref = pref[3];
    end else begin
      chk(out_valid == 1'b0, "R2 idle valid", longint'(out_valid), 0);
      chk(longint'(out_cos) == last_cos, "R6 hold cos", longint'(out_cos), last_cos);
      chk(longint'(out_ref) == last_ref, "R6 hold ref", longint'(out_ref), last_ref);
    end
    pv[3] = pv[2]; pref[3] = pref[2]; pexp[3] = pexp[2]; ptag[3] = ptag[2];
    pv[2] = pv[1]; pref[2] = pref[1]; pexp[2] = pexp[1]; ptag[2] = ptag[1];
    pv[1] = v; pref[1] = r; ptag[1] = tag;
    pexp[1] = expect_cos(c, r, longint'(sin_sigma), longint'(inv_cos));
    in_valid = v;
    in_ref = 16'(r);
    in_cos = 16'(c);
  endtask

  task automatic set_coef(longint s, longint k);
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, "R6");
    sin_sigma = 16'(s);
    inv_cos = 16'(k);
  endtask

  function automatic longint rnd16();
    return longint'($signed(16'($urandom())));
  endfunction

  task automatic random_run(int n, string tag, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom() % 4 == 0)) step(1'b0, 0, 0, "R6");
      else step(1'b1, rnd16(), rnd16(), tag);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 1; i <= 3; i++) begin pv[i] = 0; pref[i] = 0; pexp[i] = 0; ptag[i] = "R6"; end
    rst_n = 1'b0; in_valid = 1'b0; in_ref = '0; in_cos = '0;
    sin_sigma = '0; inv_cos = 16'sd16384;
    repeat (3) @(negedge clk);
    // R7: reset state at the ports
    chk(out_valid == 1'b0, "R7 valid", longint'(out_valid), 0);
    chk(out_cos == '0, "R7 cos", longint'(out_cos), 0);
    chk(out_ref == '0, "R7 ref", longint'(out_ref), 0);
    rst_n = 1'b1;

    // R4: zero phase error gives identity
    set_coef(0, 16384);
    step(1'b1, 100, -100, "R4");
    step(1'b1, -32768, 32767, "R4");
    step(1'b1, 32767, -32768, "R4");
    step(1'b1, 0, 1, "R4");
    random_run(40, "R4", 1'b1);

    // R1: about 10 degrees of error
    set_coef(2845, 16637);
    step(1'b1, 16384, 8000, "R1");
    step(1'b1, -16384, -8000, "R1");
    random_run(200, "R1", 1'b1);

    // R8: back-to-back burst
    random_run(30, "R8", 1'b0);

    // R5: saturation at both limits
    set_coef(16384, 32767);
    step(1'b1, -32768, 32767, "R5");
    step(1'b1, 32767, -32768, "R5");
    step(1'b0, 0, 0, "R6");
    step(1'b1, -20000, 30000, "R5");
    step(1'b1, 20000, -30000, "R5");

    // R1: large negative coefficients, random data
    set_coef(-9000, 21000);
    random_run(100, "R1", 1'b1);

    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, "R6");
    done = 1;
    summary();
    $finish;
  end
endmodule